// File: doc/BRIEF.md
# Buffered Zero-Overhead Loop Controller

This block sits in the instruction-fetch front end of a small signal-processing core. It owns the fetch address and issues one instruction per clock. When the decoder sees a repeat instruction, it raises a start-repeat command with the address of the last body instruction and a repeat count. The body starts at the instruction after the repeat instruction. The controller then sends the fetch address back to the first body instruction each time the last one is issued, with no branch instructions and no lost cycles.

On the first pass through a body, every fetched word is also copied into a small instruction buffer. If the whole body fits in that buffer, later passes are replayed from it. Program memory is then disabled for those passes, which saves the fetch power. A body longer than the buffer is fetched from memory on every pass.

A context stack lets loops nest. A start-repeat command inside an active loop saves the enclosing loop's start, end and count, and the enclosing loop comes back by itself when the inner loop finishes. Explicit push and pop commands suspend and restore the active loop.

Top module: `hwloop_ctrl`

## Requirements
- R1: While reset is held and right after it is released, the issued address and the memory address are `RESET_PC` (0), and memory enable is 1.
- R2: With no loop active, the issued address goes up by one every cycle, and the issued word is the program-memory word at that address.
- R3: A start-repeat command issued at address P, with end address E and count N, makes P+1..E run N+1 times in a row. N=0 gives a single pass, and N=1023 gives 1024 passes.
- R4: If the body length E-P is at most `BUF_DEPTH` (16), the first pass reads program memory. Every later pass keeps memory enable at 0 and issues, from the buffer, the same words that memory holds.
- R5: If the body length is more than `BUF_DEPTH`, memory enable stays at 1 on every pass.
- R6: After the last pass, the issued address goes on to E+1 with memory enable at 1. If no enclosing loop is saved, looping stops.
- R7: A start-repeat command inside an active loop saves the enclosing loop. When the inner loop finishes, the enclosing loop carries on by itself with its remaining count. It reads from memory until it begins a fresh pass at its own start address.
- R8: At most `NEST_MAX` (3) loops can be live at once. A start-repeat command that would go past this limit is ignored, and its end address never wraps.
- R9: A push command during an active loop suspends it: execution runs straight past its end address. A pop command restores the suspended loop. A push with no active loop, or a pop with nothing saved, has no effect. If commands arrive together, start-repeat has priority over push, and push over pop.
- R10: Memory enable is 0 only while the issued address lies inside the active loop body.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rpt_start_i | input | 1 | Start-repeat command for the instruction issued this cycle |
| rpt_end_i | input | PC_W | Address of the last body instruction |
| rpt_cnt_i | input | CNT_W | Repeat count; N gives N+1 passes |
| push_i | input | 1 | Suspend the active loop and save it |
| pop_i | input | 1 | Restore the most recently saved loop |
| mem_rdata_i | input | INSTR_W | Program-memory word at `mem_addr_o`, same cycle |
| mem_addr_o | output | PC_W | Program-memory address |
| mem_en_o | output | 1 | Program-memory enable |
| issue_pc_o | output | PC_W | Address of the instruction issued this cycle |
| issue_instr_o | output | INSTR_W | Instruction issued this cycle |
| next_pc_o | output | PC_W | Address to be issued next cycle |

## Verification
The hardest state to reach is the hand-back from a finished inner loop to its enclosing loop. At that point the buffer holds the inner body. The outer loop must resume from memory and must not be replayed from the stale buffer contents. The bench reaches this state with a small program table. It raises start-repeat, push or pop on the cycle the matching address is issued, so the nested and overflow cases come out of ordinary instruction flow. The program memory model returns a poison word whenever it is disabled, so any replay from the buffer that is wrong or stale shows up in the issued word.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    // Loop controller states
    typedef enum logic [1:0] {
        LP_IDLE   = 2'd0,   // no active loop, memory fetch
        LP_FILL   = 2'd1,   // loop active, memory fetch (captures when allowed)
        LP_REPLAY = 2'd2    // loop active, words come from the buffer
    } lp_state_e;

endpackage

// File: rtl/hwloop_buffer.sv
module hwloop_buffer #(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned INSTR_W = 16,
    parameter int unsigned IDX_W   = 4
) (
    input  logic               clk,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [INSTR_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [INSTR_W-1:0] rd_data_o
);

    logic [INSTR_W-1:0] slot_q [DEPTH];
    logic [INSTR_W-1:0] rd_mux;

    // One register row per slot, written at its own offset in the body
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                slot_q[g] <= wr_data_i;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx_i == IDX_W'(i)) begin
                rd_mux = slot_q[i];
            end
        end
    end

    assign rd_data_o = rd_mux;

endmodule

// File: rtl/hwloop_stack.sv
module hwloop_stack #(
    parameter int unsigned DEPTH   = 2,
    parameter int unsigned ENTRY_W = 41,
    parameter int unsigned LVL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic [ENTRY_W-1:0] push_data_i,
    output logic [ENTRY_W-1:0] top_o,
    output logic [LVL_W-1:0]   level_o
);

    logic [ENTRY_W-1:0] ent_q [DEPTH];
    logic [ENTRY_W-1:0] ent_d [DEPTH];
    logic [LVL_W-1:0]   level_q, level_d;
    logic               can_push, can_pop;

    assign can_push = push_i && (level_q < LVL_W'(DEPTH));
    assign can_pop  = pop_i && !push_i && (level_q != '0);

    always_comb begin
        level_d = level_q;
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (can_push) begin
            level_d = level_q + 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                if (level_q == LVL_W'(i)) begin
                    ent_d[i] = push_data_i;
                end
            end
        end else if (can_pop) begin
            level_d = level_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            level_q <= level_d;
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (level_q == LVL_W'(i + 1)) begin
                top_o = ent_q[i];
            end
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
    parameter int unsigned PC_W      = 12,
    parameter int unsigned INSTR_W   = 16,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned BUF_DEPTH = 16,
    parameter int unsigned NEST_MAX  = 3,
    parameter int unsigned RESET_PC  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rpt_start_i,
    input  logic [PC_W-1:0]    rpt_end_i,
    input  logic [CNT_W-1:0]   rpt_cnt_i,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic [INSTR_W-1:0] mem_rdata_i,
    output logic [PC_W-1:0]    mem_addr_o,
    output logic               mem_en_o,
    output logic [PC_W-1:0]    issue_pc_o,
    output logic [INSTR_W-1:0] issue_instr_o,
    output logic [PC_W-1:0]    next_pc_o
);
    import hwloop_pkg::*;

    localparam int unsigned STK_DEPTH = NEST_MAX - 1;
    localparam int unsigned IDX_W     = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
    localparam int unsigned LVL_W     = $clog2(STK_DEPTH + 1);

    // Saved loop context
    typedef struct packed {
        logic [PC_W-1:0]  start;
        logic [PC_W-1:0]  last;
        logic [CNT_W-1:0] cnt;
        logic             fits;
    } ctx_t;

    localparam int unsigned ENTRY_W = $bits(ctx_t);

    // Full controller state
    typedef struct packed {
        logic [PC_W-1:0]  pc;
        lp_state_e        st;
        logic [PC_W-1:0]  start;
        logic [PC_W-1:0]  last;
        logic [CNT_W-1:0] cnt;
        logic             fits;
        logic             fill_ok;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic               active, at_end, stk_full, stk_empty;
    logic               rpt_ok, push_ok, pop_ok;
    logic               stk_push, stk_pop;
    logic [PC_W-1:0]    new_len;
    logic               new_fits;
    ctx_t               push_ctx, top_ctx;
    logic [ENTRY_W-1:0] stk_top;
    logic [LVL_W-1:0]   stk_level;
    logic [IDX_W-1:0]   buf_idx;
    logic               buf_we;
    logic [INSTR_W-1:0] buf_word;

    // Aliases observed by the bound checker
    logic [1:0]         loop_st;
    logic [PC_W-1:0]    loop_start, loop_last;
    logic [CNT_W-1:0]   loop_cnt;

    assign active    = (cur_q.st != LP_IDLE);
    assign at_end    = active && (cur_q.pc == cur_q.last);
    assign stk_full  = (stk_level == LVL_W'(STK_DEPTH));
    assign stk_empty = (stk_level == '0);

    // Command arbitration: start-repeat, then push, then pop
    assign rpt_ok  = rpt_start_i && (!active || !stk_full);
    assign push_ok = !rpt_start_i && push_i && active && !stk_full;
    assign pop_ok  = !rpt_start_i && !push_i && pop_i && !stk_empty;

    // Body length of a new loop is end - (pc + 1) + 1
    assign new_len  = rpt_end_i - cur_q.pc;
    assign new_fits = (rpt_end_i > cur_q.pc) && (new_len <= PC_W'(BUF_DEPTH));

    assign push_ctx = '{start: cur_q.start, last: cur_q.last,
                        cnt: cur_q.cnt, fits: cur_q.fits};
    assign top_ctx  = ctx_t'(stk_top);

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.pc = cur_q.pc + 1'b1;
        stk_push = 1'b0;
        stk_pop  = 1'b0;

        if (rpt_ok) begin
            stk_push      = active;
            nxt_d.st      = LP_FILL;
            nxt_d.start   = cur_q.pc + 1'b1;
            nxt_d.last    = rpt_end_i;
            nxt_d.cnt     = rpt_cnt_i;
            nxt_d.fits    = new_fits;
            nxt_d.fill_ok = 1'b1;
        end else if (push_ok) begin
            stk_push      = 1'b1;
            nxt_d.st      = LP_IDLE;
            nxt_d.fill_ok = 1'b0;
        end else if (pop_ok) begin
            stk_pop       = 1'b1;
            nxt_d.st      = LP_FILL;
            nxt_d.start   = top_ctx.start;
            nxt_d.last    = top_ctx.last;
            nxt_d.cnt     = top_ctx.cnt;
            nxt_d.fits    = top_ctx.fits;
            nxt_d.fill_ok = 1'b0;
        end else if (at_end) begin
            if (cur_q.cnt != '0) begin
                nxt_d.cnt = cur_q.cnt - 1'b1;
                nxt_d.pc  = cur_q.start;
                if (cur_q.st == LP_REPLAY) begin
                    nxt_d.st = LP_REPLAY;
                end else if (cur_q.fill_ok && cur_q.fits) begin
                    nxt_d.st = LP_REPLAY;
                end else begin
                    nxt_d.st      = LP_FILL;
                    nxt_d.fill_ok = 1'b1;
                end
            end else if (!stk_empty) begin
                stk_pop       = 1'b1;
                nxt_d.st      = LP_FILL;
                nxt_d.start   = top_ctx.start;
                nxt_d.last    = top_ctx.last;
                nxt_d.cnt     = top_ctx.cnt;
                nxt_d.fits    = top_ctx.fits;
                nxt_d.fill_ok = 1'b0;
            end else begin
                nxt_d.st      = LP_IDLE;
                nxt_d.fill_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{pc: PC_W'(RESET_PC), st: LP_IDLE, start: '0, last: '0,
                       cnt: '0, fits: 1'b0, fill_ok: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    // Buffer slot is the offset of the issued word inside the body
    assign buf_idx = IDX_W'(cur_q.pc - cur_q.start);
    assign buf_we  = (cur_q.st == LP_FILL) && cur_q.fill_ok && cur_q.fits;

    hwloop_buffer #(
        .DEPTH   (BUF_DEPTH),
        .INSTR_W (INSTR_W),
        .IDX_W   (IDX_W)
    ) buf_i (
        .clk       (clk),
        .wr_en_i   (buf_we),
        .wr_idx_i  (buf_idx),
        .wr_data_i (mem_rdata_i),
        .rd_idx_i  (buf_idx),
        .rd_data_o (buf_word)
    );

    hwloop_stack #(
        .DEPTH   (STK_DEPTH),
        .ENTRY_W (ENTRY_W),
        .LVL_W   (LVL_W)
    ) stk_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (stk_push),
        .pop_i       (stk_pop),
        .push_data_i (push_ctx),
        .top_o       (stk_top),
        .level_o     (stk_level)
    );

    assign mem_addr_o    = cur_q.pc;
    assign mem_en_o      = (cur_q.st != LP_REPLAY);
    assign issue_pc_o    = cur_q.pc;
    assign issue_instr_o = (cur_q.st == LP_REPLAY) ? buf_word : mem_rdata_i;
    assign next_pc_o     = nxt_d.pc;

    assign loop_st    = cur_q.st;
    assign loop_start = cur_q.start;
    assign loop_last  = cur_q.last;
    assign loop_cnt   = cur_q.cnt;

endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
    parameter int unsigned PC_W      = 12,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned LVL_W     = 2,
    parameter int unsigned STK_DEPTH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rpt_i,
    input logic             push_i,
    input logic             pop_i,
    input logic             mem_en_i,
    input logic [PC_W-1:0]  issue_pc_i,
    input logic [1:0]       st_i,
    input logic [PC_W-1:0]  start_i,
    input logic [PC_W-1:0]  last_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [LVL_W-1:0] level_i
);

    logic quiet;
    assign quiet = !rpt_i && !push_i && !pop_i;

    // Memory is off only inside the running body
    assert_replay_in_body_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en_i |-> (issue_pc_i >= start_i && issue_pc_i <= last_i));

    // Saved contexts never exceed the stack size
    assert_stack_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        level_i <= LVL_W'(STK_DEPTH));

    // A wrap with count left decrements the count and returns to the start
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i != 2'd0 && issue_pc_i == last_i && cnt_i != '0 && quiet)
        |=> (cnt_i == CNT_W'($past(cnt_i) - 1'b1) && issue_pc_i == $past(start_i)));

    // Replay begins only at a wrap, on the first body word
    assert_replay_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_en_i) |-> (issue_pc_i == start_i && $past(issue_pc_i) == $past(last_i)));

    // Final pass without saved context leaves the loop and falls through
    assert_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i != 2'd0 && issue_pc_i == last_i && cnt_i == '0 && level_i == '0 && quiet)
        |=> (st_i == 2'd0 && mem_en_i && issue_pc_i == PC_W'($past(issue_pc_i) + 1'b1)));

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(
    .PC_W      (PC_W),
    .CNT_W     (CNT_W),
    .LVL_W     (LVL_W),
    .STK_DEPTH (STK_DEPTH)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rpt_i      (rpt_start_i),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .mem_en_i   (mem_en_o),
    .issue_pc_i (issue_pc_o),
    .st_i       (loop_st),
    .start_i    (loop_start),
    .last_i     (loop_last),
    .cnt_i      (loop_cnt),
    .level_i    (stk_level)
);

// File: tb/hwloop_ctrl_tb_top.sv
module hwloop_ctrl_tb_top;

    localparam int PC_W = 12, INSTR_W = 16, CNT_W = 16;
    localparam int NEST_MAX = 3, SD = NEST_MAX - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic               rpt_start = 1'b0, push = 1'b0, pop = 1'b0;
    logic [PC_W-1:0]    rpt_end = '0;
    logic [CNT_W-1:0]   rpt_cnt = '0;
    logic [INSTR_W-1:0] mem_rdata;
    logic [PC_W-1:0]    mem_addr, issue_pc, next_pc;
    logic               mem_en;
    logic [INSTR_W-1:0] issue_instr;

    hwloop_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .rpt_start_i(rpt_start), .rpt_end_i(rpt_end), .rpt_cnt_i(rpt_cnt),
        .push_i(push), .pop_i(pop), .mem_rdata_i(mem_rdata),
        .mem_addr_o(mem_addr), .mem_en_o(mem_en), .issue_pc_o(issue_pc),
        .issue_instr_o(issue_instr), .next_pc_o(next_pc)
    );

    function automatic logic [INSTR_W-1:0] mem_word(input logic [PC_W-1:0] a);
        return INSTR_W'(32'(a) * 32'h9E37 + 32'h1234);
    endfunction

    // Program memory; a disabled read returns poison
    always_comb mem_rdata = mem_en ? mem_word(mem_addr) : 16'hDEAD;

    int n_cmp = 0, n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Program table: commands raised when the matching address is issued
    int rpt_at[4], rpt_e[4], rpt_c[4];
    int push_at, pop_at, watch_at;

    // Expected loop semantics
    int m_pc, m_start, m_last, m_cnt, m_sp;
    bit m_act;
    int ms_start[4], ms_last[4], ms_cnt[4];

    task automatic clear_prog();
        for (int k = 0; k < 4; k++) begin
            rpt_at[k] = -1; rpt_e[k] = 0; rpt_c[k] = 0;
        end
        push_at = -1; pop_at = -1; watch_at = -1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rpt_start = 1'b0; push = 1'b0; pop = 1'b0;
        rpt_end = '0; rpt_cnt = '0;
        repeat (3) @(negedge clk);
        check(issue_pc == 0 && mem_en == 1'b1, "R1", "pc/en in reset",
              {issue_pc, 3'b0, mem_en}, 1);
        rst_n = 1'b1;
        m_pc = 0; m_act = 0; m_sp = 0; m_start = 0; m_last = 0; m_cnt = 0;
    endtask

    task automatic m_save();
        ms_start[m_sp] = m_start; ms_last[m_sp] = m_last; ms_cnt[m_sp] = m_cnt;
        m_sp++;
    endtask

    task automatic m_restore();
        m_sp--;
        m_start = ms_start[m_sp]; m_last = ms_last[m_sp]; m_cnt = ms_cnt[m_sp];
        m_act = 1;
    endtask

    task automatic model_step(input int p, input bit r, input int e, input int c,
                              input bit pu, input bit po);
        if (r && (!m_act || m_sp < SD)) begin
            if (m_act) m_save();
            m_act = 1; m_start = p + 1; m_last = e; m_cnt = c; m_pc = p + 1;
        end else if (!r && pu && m_act && m_sp < SD) begin
            m_save(); m_act = 0; m_pc = p + 1;
        end else if (!r && !pu && po && m_sp > 0) begin
            m_restore(); m_pc = p + 1;
        end else if (m_act && p == m_last) begin
            if (m_cnt != 0) begin
                m_cnt--; m_pc = m_start;
            end else begin
                m_pc = p + 1;
                if (m_sp > 0) m_restore();
                else m_act = 0;
            end
        end else begin
            m_pc = p + 1;
        end
    endtask

    task automatic run_prog(input string req, input int cycles,
                            output int lows, output int hits);
        lows = 0; hits = 0;
        for (int i = 0; i < cycles; i++) begin
            int p;
            int ri;
            bit r, pu, po;
            p = int'(issue_pc);
            check(p == m_pc, req, "issued address", p, m_pc);
            check(issue_instr == mem_word(issue_pc), req, "issued word",
                  issue_instr, mem_word(issue_pc));
            if (!mem_en) lows++;
            if (p == watch_at) hits++;
            r = 0; ri = 0;
            for (int k = 0; k < 4; k++) begin
                if (rpt_at[k] == m_pc) begin r = 1; ri = k; end
            end
            pu = (push_at == m_pc);
            po = (pop_at == m_pc);
            rpt_start = r;
            rpt_end   = PC_W'(rpt_e[ri]);
            rpt_cnt   = CNT_W'(rpt_c[ri]);
            push      = pu;
            pop       = po;
            model_step(m_pc, r, rpt_e[ri], rpt_c[ri], pu, po);
            @(negedge clk);
        end
        rpt_start = 1'b0; push = 1'b0; pop = 1'b0;
    endtask

    int lows, hits;

    task automatic t_reset();
        clear_prog(); do_reset();
        check(mem_addr == 0 && mem_en == 1'b1, "R1", "after release",
              mem_addr, 0);
    endtask

    task automatic t_linear();  // R2, plus ignored push/pop (R9)
        clear_prog(); do_reset();
        push_at = 3; pop_at = 5;
        run_prog("R2/R9", 16, lows, hits);
        check(lows == 0, "R2", "memory-off cycles", lows, 0);
    endtask

    task automatic t_simple();  // three passes of a three-word body
        clear_prog(); do_reset();
        rpt_at[0] = 2; rpt_e[0] = 5; rpt_c[0] = 2; watch_at = 3;
        run_prog("R3/R6", 14, lows, hits);
        check(hits == 3, "R3", "passes", hits, 3);
        check(lows == 6, "R4", "replayed cycles", lows, 6);
        check(mem_en == 1'b1, "R6", "enable after exit", mem_en, 1);
    endtask

    task automatic t_zero();
        clear_prog(); do_reset();
        rpt_at[0] = 1; rpt_e[0] = 4; rpt_c[0] = 0; watch_at = 2;
        run_prog("R3", 10, lows, hits);
        check(hits == 1, "R3", "single pass", hits, 1);
        check(lows == 0, "R4", "no replay on one pass", lows, 0);
    endtask

    task automatic t_long();
        clear_prog(); do_reset();
        rpt_at[0] = 1; rpt_e[0] = 20; rpt_c[0] = 1; watch_at = 2;
        run_prog("R5", 45, lows, hits);
        check(hits == 2, "R5", "passes", hits, 2);
        check(lows == 0, "R5", "memory-off cycles", lows, 0);
    endtask

    task automatic t_fit16();
        clear_prog(); do_reset();
        rpt_at[0] = 1; rpt_e[0] = 17; rpt_c[0] = 1; watch_at = 2;
        run_prog("R4", 40, lows, hits);
        check(hits == 2, "R4", "passes", hits, 2);
        check(lows == 16, "R4", "full-buffer replay", lows, 16);
    endtask

    task automatic t_1024();
        clear_prog(); do_reset();
        rpt_at[0] = 3; rpt_e[0] = 4; rpt_c[0] = 1023; watch_at = 4;
        run_prog("R3", 1035, lows, hits);
        check(hits == 1024, "R3", "passes of count 1023", hits, 1024);
        check(lows == 1023, "R4", "replayed cycles", lows, 1023);
    endtask

    task automatic t_nest();
        clear_prog(); do_reset();
        rpt_at[0] = 2; rpt_e[0] = 10; rpt_c[0] = 1;
        rpt_at[1] = 4; rpt_e[1] = 6;  rpt_c[1] = 2;
        watch_at = 5;
        run_prog("R7", 32, lows, hits);
        check(hits == 6, "R7", "inner passes", hits, 6);
        check(lows == 8, "R7", "replayed cycles", lows, 8);
    endtask

    task automatic t_depth();
        clear_prog(); do_reset();
        rpt_at[0] = 1; rpt_e[0] = 11; rpt_c[0] = 0;
        rpt_at[1] = 2; rpt_e[1] = 10; rpt_c[1] = 0;
        rpt_at[2] = 3; rpt_e[2] = 9;  rpt_c[2] = 0;
        rpt_at[3] = 4; rpt_e[3] = 5;  rpt_c[3] = 3;
        watch_at = 5;
        run_prog("R8", 16, lows, hits);
        check(hits == 1, "R8", "overflow loop passes", hits, 1);
        check(lows == 0, "R8", "memory-off cycles", lows, 0);
    endtask

    task automatic t_pushpop();
        clear_prog(); do_reset();
        rpt_at[0] = 1; rpt_e[0] = 7; rpt_c[0] = 1;
        push_at = 3; pop_at = 5; watch_at = 2;
        run_prog("R9", 20, lows, hits);
        check(hits == 2, "R9", "restored loop passes", hits, 2);
        clear_prog(); do_reset();
        rpt_at[0] = 1; rpt_e[0] = 7; rpt_c[0] = 1;
        push_at = 3; watch_at = 2;
        run_prog("R9", 14, lows, hits);
        check(hits == 1, "R9", "suspended loop passes", hits, 1);
    endtask

    initial begin
        t_reset();
        t_linear();
        t_simple();
        t_zero();
        t_long();
        t_fit16();
        t_1024();
        t_nest();
        t_depth();
        t_pushpop();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule